// File: doc/BRIEF.md
# Folded Radix-4 64-Point Inverse FFT

This block computes the inverse discrete Fourier transform of one 64-point complex symbol. Each sample has a signed fixed-point real part and a signed fixed-point imaginary part. The transform runs as three radix-4 passes (4 x 4 x 4). Only one pass worth of butterfly hardware exists, and the controller runs it three times over an in-place sample store. The parameter `NBFLY` sets how many radix-4 butterflies that hardware holds. It may be 1, 2, 4, 8 or 16. Fewer butterflies means smaller muxes and arithmetic but more clock cycles per symbol. A pass covers all 16 butterfly positions in `16/NBFLY` cycles. Whatever the setting, the arithmetic done at each butterfly position is the same.

A whole symbol enters as one wide word on a valid/ready handshake, and a whole result leaves the same way. The input side is ready only while the block is idle. Once a symbol has been taken, input ready stays low until the consumer has taken the result. On the output side, valid is held and the result stays frozen for as long as the consumer holds ready low. Each butterfly divides its output by four with rounding, so the result carries an overall scale of 1/64. Because of this, the result never overflows as long as no input sample has a complex magnitude above full scale.

Top module: `ifft64_folded`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A symbol is captured on the clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the result is taken. While it is 0, values on `in_valid`, `in_re` and `in_im` have no effect on the result.
- R3: `out_valid` first reads 1 exactly `48/NBFLY` clock edges after the capturing edge. That is 12 edges for NBFLY=4, 3 for 16 and 48 for 1.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_re`/`out_im` do not change.
- R5: After an edge with `out_valid` and `out_ready` both 1, `out_valid` is 0 and `in_ready` is 1.
- R6: Sample n of the output is (1/64)·Σk x[k]·exp(+j2πkn/64), within ±2 LSB on each part. Sample n occupies bits [n·W +: W] of the output ports, and input sample k occupies bits [k·W +: W] of the input ports. All values are W-bit two's complement, and every input sample has magnitude at most 2^(W-1)-1.
- R7: A constant input with parts of about 0.7 of full scale produces output sample 0 equal to that constant and zeros elsewhere. No value wraps around.
- R8: Builds with different `NBFLY` values give bit-identical results for the same symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input symbol present |
| in_ready | output | 1 | Block idle and able to take a symbol |
| in_re | input | 64·W | Real parts, sample k at [k·W +: W] |
| in_im | input | 64·W | Imaginary parts, same layout |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_re | output | 64·W | Real parts of the result, natural order |
| out_im | output | 64·W | Imaginary parts of the result, natural order |

## Verification
The bench builds three copies of the block with NBFLY set to 4, 16 and 1, feeds all three the same symbols, and starts them on the same edge. This gives three distinct latencies to check, and it allows a bit-for-bit comparison between the fully parallel schedule and the most serial one. The bench sweeps a unit impulse across all 64 input positions, which exercises every twiddle exponent and every address of the in-place store. It then adds a near-full-scale constant and several random symbols, and checks each against a floating-point inverse DFT.

// File: rtl/ifft_pkg.sv
package ifft_pkg;
  localparam int NPTS    = 64;
  localparam int TW_W    = 16;
  localparam int TW_FRAC = 14;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} fsm_t;

  // sin(2*pi*r/64) in Q14 for r = 0..16
  function automatic logic signed [15:0] qsin(input logic [4:0] r);
    case (r)
      5'd0:  return 16'sd0;
      5'd1:  return 16'sd1606;
      5'd2:  return 16'sd3196;
      5'd3:  return 16'sd4756;
      5'd4:  return 16'sd6270;
      5'd5:  return 16'sd7723;
      5'd6:  return 16'sd9102;
      5'd7:  return 16'sd10394;
      5'd8:  return 16'sd11585;
      5'd9:  return 16'sd12665;
      5'd10: return 16'sd13623;
      5'd11: return 16'sd14449;
      5'd12: return 16'sd15137;
      5'd13: return 16'sd15679;
      5'd14: return 16'sd16069;
      5'd15: return 16'sd16305;
      default: return 16'sd16384;
    endcase
  endfunction

  // {cos, sin} of +2*pi*e/64, both Q14
  function automatic logic [31:0] twiddle(input logic [5:0] e);
    logic [4:0] r;
    logic [4:0] rc;
    logic signed [15:0] s0;
    logic signed [15:0] c0;
    r  = {1'b0, e[3:0]};
    rc = 5'd16 - r;
    s0 = qsin(r);
    c0 = qsin(rc);
    case (e[5:4])
      2'd0:    return {c0, s0};
      2'd1:    return {-s0, c0};
      2'd2:    return {-c0, -s0};
      default: return {s0, -c0};
    endcase
  endfunction

  // store address of leg m of butterfly b in pass st (decimation in frequency)
  function automatic logic [5:0] bfly_addr(input logic [1:0] st, input logic [3:0] b,
                                           input logic [1:0] m);
    int span;
    int grp;
    int pos;
    span = 16 >> (2 * int'(st));
    grp  = int'(b) / span;
    pos  = int'(b) % span;
    return 6'(grp * 4 * span + pos + int'(m) * span);
  endfunction

  // twiddle exponent applied to leg m of butterfly b in pass st
  function automatic logic [5:0] tw_exp(input logic [1:0] st, input logic [3:0] b,
                                        input logic [1:0] m);
    int span;
    int pos;
    span = 16 >> (2 * int'(st));
    pos  = int'(b) % span;
    return 6'((pos * int'(m)) << (2 * int'(st)));
  endfunction

  // base-4 digit reversal of a 6-bit index
  function automatic logic [5:0] digit_rev(input logic [5:0] n);
    return {n[1:0], n[3:2], n[5:4]};
  endfunction
endpackage

// File: rtl/ifft_bfly4.sv
module ifft_bfly4 #(
  parameter int W = 16
) (
  input  logic [3:0][W-1:0] a_re,
  input  logic [3:0][W-1:0] a_im,
  output logic [3:0][W-1:0] y_re,
  output logic [3:0][W-1:0] y_im
);
  localparam int EW = W + 2;

  logic signed [EW-1:0] r0, r1, r2, r3, i0, i1, i2, i3;
  logic signed [EW-1:0] s_re [4];
  logic signed [EW-1:0] s_im [4];
  logic signed [EW-1:0] t_re [4];
  logic signed [EW-1:0] t_im [4];

  always_comb begin
    r0 = EW'($signed(a_re[0]));
    r1 = EW'($signed(a_re[1]));
    r2 = EW'($signed(a_re[2]));
    r3 = EW'($signed(a_re[3]));
    i0 = EW'($signed(a_im[0]));
    i1 = EW'($signed(a_im[1]));
    i2 = EW'($signed(a_im[2]));
    i3 = EW'($signed(a_im[3]));
    // inverse radix-4 kernel: y_m = sum_n x_n * (+j)^(n*m)
    s_re[0] = r0 + r1 + r2 + r3;
    s_im[0] = i0 + i1 + i2 + i3;
    s_re[1] = r0 - i1 - r2 + i3;
    s_im[1] = i0 + r1 - i2 - r3;
    s_re[2] = r0 - r1 + r2 - r3;
    s_im[2] = i0 - i1 + i2 - i3;
    s_re[3] = r0 + i1 - r2 - i3;
    s_im[3] = i0 - r1 - i2 + r3;
    for (int m = 0; m < 4; m++) begin
      t_re[m] = (s_re[m] + EW'(2)) >>> 2;
      t_im[m] = (s_im[m] + EW'(2)) >>> 2;
      y_re[m] = t_re[m][W-1:0];
      y_im[m] = t_im[m][W-1:0];
    end
  end
endmodule

// File: rtl/ifft_twmul.sv
module ifft_twmul
  import ifft_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic        [5:0]   w_exp,
  output logic signed [W-1:0] z_re,
  output logic signed [W-1:0] z_im
);
  localparam int PW = W + TW_W + 1;
  localparam logic signed [PW-1:0] MAXV = PW'({(W-1){1'b1}});
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (TW_FRAC - 1);

  logic [31:0] tw;
  logic signed [TW_W-1:0] tc, ts;
  logic signed [PW-1:0] pr, pi, qr, qi;

  assign tw = twiddle(w_exp);
  assign tc = tw[31:16];
  assign ts = tw[15:0];

  always_comb begin
    pr = PW'(a_re) * PW'(tc) - PW'(a_im) * PW'(ts);
    pi = PW'(a_re) * PW'(ts) + PW'(a_im) * PW'(tc);
    qr = (pr + RND) >>> TW_FRAC;
    qi = (pi + RND) >>> TW_FRAC;
    if (qr > MAXV)      z_re = MAXV[W-1:0];
    else if (qr < MINV) z_re = MINV[W-1:0];
    else                z_re = qr[W-1:0];
    if (qi > MAXV)      z_im = MAXV[W-1:0];
    else if (qi < MINV) z_im = MINV[W-1:0];
    else                z_im = qi[W-1:0];
  end
endmodule

// File: rtl/ifft_ctrl.sv
module ifft_ctrl
  import ifft_pkg::*;
#(
  parameter int STEPS = 4,
  parameter int SW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          load,
  output logic          compute,
  output logic [1:0]    stage,
  output logic [SW-1:0] step
);
  localparam int TOTAL = 3 * STEPS;

  fsm_t state;
  logic [7:0] run_cnt;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign compute   = (state == ST_RUN);
  assign load      = in_ready && in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      stage <= '0;
      step  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_RUN;
          stage <= '0;
          step  <= '0;
        end
        ST_RUN: begin
          if (step == SW'(STEPS - 1)) begin
            step <= '0;
            if (stage == 2'd2) state <= ST_DONE;
            else               stage <= stage + 2'd1;
          end else begin
            step <= step + SW'(1);
          end
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // cycle counter for the latency check only
  always_ff @(posedge clk) begin
    if (!rst_n)       run_cnt <= '0;
    else if (load)    run_cnt <= '0;
    else if (compute) run_cnt <= run_cnt + 8'd1;
  end

  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !in_ready && !out_valid); // R2
  AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> in_ready); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> run_cnt == 8'(TOTAL)); // R3
  AST_STAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    compute |-> stage != 2'd3); // R3
  AST_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid); // R5
endmodule

// File: rtl/ifft64_folded.sv
module ifft64_folded
  import ifft_pkg::*;
#(
  parameter int W     = 16,
  parameter int NBFLY = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [NPTS*W-1:0]  in_re,
  input  logic [NPTS*W-1:0]  in_im,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [NPTS*W-1:0]  out_re,
  output logic [NPTS*W-1:0]  out_im
);
  localparam int STEPS = 16 / NBFLY;
  localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic signed [W-1:0] mem_re [NPTS];
  logic signed [W-1:0] mem_im [NPTS];

  logic          load, compute;
  logic [1:0]    stage;
  logic [SW-1:0] step;

  ifft_ctrl #(.STEPS(STEPS), .SW(SW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .load(load), .compute(compute),
    .stage(stage), .step(step)
  );

  logic [5:0]         addr [NBFLY][4];
  logic [3:0][W-1:0]  xr   [NBFLY];
  logic [3:0][W-1:0]  xi   [NBFLY];
  logic [3:0][W-1:0]  yr   [NBFLY];
  logic [3:0][W-1:0]  yi   [NBFLY];
  logic [3:0][W-1:0]  zr   [NBFLY];
  logic [3:0][W-1:0]  zi   [NBFLY];

  for (genvar u = 0; u < NBFLY; u++) begin : g_lane
    logic [3:0] b_idx;
    assign b_idx = 4'(int'(step) * NBFLY + u);

    for (genvar m = 0; m < 4; m++) begin : g_leg
      assign addr[u][m] = bfly_addr(stage, b_idx, 2'(m));
      assign xr[u][m]   = mem_re[addr[u][m]];
      assign xi[u][m]   = mem_im[addr[u][m]];
    end

    ifft_bfly4 #(.W(W)) u_bfly (
      .a_re(xr[u]), .a_im(xi[u]), .y_re(yr[u]), .y_im(yi[u])
    );

    for (genvar m = 0; m < 4; m++) begin : g_tw
      if (m == 0) begin : g_pass
        assign zr[u][m] = yr[u][m];
        assign zi[u][m] = yi[u][m];
      end else begin : g_mul
        logic [5:0] e;
        logic signed [W-1:0] pr, pi;
        assign e = tw_exp(stage, b_idx, 2'(m));
        ifft_twmul #(.W(W)) u_mul (
          .a_re($signed(yr[u][m])), .a_im($signed(yi[u][m])), .w_exp(e),
          .z_re(pr), .z_im(pi)
        );
        assign zr[u][m] = pr;
        assign zi[u][m] = pi;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      for (int n = 0; n < NPTS; n++) begin
        mem_re[n] <= in_re[n*W +: W];
        mem_im[n] <= in_im[n*W +: W];
      end
    end else if (compute) begin
      for (int u = 0; u < NBFLY; u++) begin
        for (int m = 0; m < 4; m++) begin
          mem_re[addr[u][m]] <= zr[u][m];
          mem_im[addr[u][m]] <= zi[u][m];
        end
      end
    end
  end

  // results sit in digit-reversed order; unscramble at the port
  always_comb begin
    for (int n = 0; n < NPTS; n++) begin
      out_re[n*W +: W] = mem_re[digit_rev(6'(n))];
      out_im[n*W +: W] = mem_im[digit_rev(6'(n))];
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im)); // R4
endmodule

// File: tb/ifft64_folded_test.sv
`timescale 1ns/1ps
module ifft64_folded_test;
  localparam int W = 16;
  localparam int N = 64;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [N*W-1:0] in_re = '0;
  logic [N*W-1:0] in_im = '0;
  logic rdy [3];
  logic vld [3];
  logic [N*W-1:0] ore [3];
  logic [N*W-1:0] oim [3];

  ifft64_folded #(.W(W), .NBFLY(4)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[0]),
    .in_re(in_re), .in_im(in_im), .out_valid(vld[0]), .out_ready(out_ready),
    .out_re(ore[0]), .out_im(oim[0]));
  ifft64_folded #(.W(W), .NBFLY(16)) uut_full (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[1]),
    .in_re(in_re), .in_im(in_im), .out_valid(vld[1]), .out_ready(out_ready),
    .out_re(ore[1]), .out_im(oim[1]));
  ifft64_folded #(.W(W), .NBFLY(1)) uut_one (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[2]),
    .in_re(in_re), .in_im(in_im), .out_valid(vld[2]), .out_ready(out_ready),
    .out_re(ore[2]), .out_im(oim[2]));

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int xr [N];
  int xi [N];
  int exp_lat [3] = '{12, 3, 48};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int sx(input logic [N*W-1:0] v, input int n);
    return int'($signed(v[n*W +: W]));
  endfunction

  task automatic run_symbol(input string req);
    int lat [3];
    int t;
    logic [N*W-1:0] snap_re;
    logic [N*W-1:0] snap_im;
    for (int n = 0; n < N; n++) begin
      in_re[n*W +: W] = W'(xr[n]);
      in_im[n*W +: W] = W'(xi[n]);
    end
    for (int i = 0; i < 3; i++) check(rdy[i] == 1'b1, "R2", "ready before symbol", int'(rdy[i]), 1);
    in_valid = 1'b1;
    @(negedge clk);
    // keep valid high with garbage data: must be ignored while busy (R2)
    in_re = ~in_re;
    in_im = ~in_im;
    for (int i = 0; i < 3; i++) begin
      check(rdy[i] == 1'b0, "R2", "ready low while busy", int'(rdy[i]), 0);
      lat[i] = -1;
    end
    t = 0;
    while (t < 200) begin
      for (int i = 0; i < 3; i++) if (lat[i] < 0 && vld[i]) lat[i] = t;
      if (lat[0] >= 0 && lat[1] >= 0 && lat[2] >= 0) break;
      @(negedge clk);
      t++;
    end
    for (int i = 0; i < 3; i++) check(lat[i] == exp_lat[i], "R3", "latency", lat[i], exp_lat[i]);
    snap_re = ore[0];
    snap_im = oim[0];
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) check(vld[i] == 1'b1, "R4", "valid held", int'(vld[i]), 1);
    check(ore[0] == snap_re && oim[0] == snap_im, "R4", "data held", int'(ore[0] == snap_re), 1);
    in_valid = 1'b0;
    for (int n = 0; n < N; n++) begin
      real sr = 0.0;
      real si = 0.0;
      real th;
      int ar;
      int ai;
      for (int k = 0; k < N; k++) begin
        th = 2.0 * PI * real'((k * n) % N) / real'(N);
        sr += real'(xr[k]) * $cos(th) - real'(xi[k]) * $sin(th);
        si += real'(xr[k]) * $sin(th) + real'(xi[k]) * $cos(th);
      end
      sr = sr / real'(N);
      si = si / real'(N);
      ar = sx(ore[0], n);
      ai = sx(oim[0], n);
      check((real'(ar) - sr) <= 2.0 && (sr - real'(ar)) <= 2.0, req, "real part", ar, int'(sr));
      check((real'(ai) - si) <= 2.0 && (si - real'(ai)) <= 2.0, req, "imag part", ai, int'(si));
    end
    check(ore[1] == ore[0] && oim[1] == oim[0], "R8", "NBFLY=16 vs 4", sx(ore[1], 0), sx(ore[0], 0));
    check(ore[2] == ore[0] && oim[2] == oim[0], "R8", "NBFLY=1 vs 4", sx(ore[2], 0), sx(ore[0], 0));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check(vld[i] == 1'b0, "R5", "valid drops after pop", int'(vld[i]), 0);
      check(rdy[i] == 1'b1, "R5", "ready after pop", int'(rdy[i]), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check(rdy[i] == 1'b1, "R1", "ready after reset", int'(rdy[i]), 1);
      check(vld[i] == 1'b0, "R1", "valid after reset", int'(vld[i]), 0);
    end
    // impulse swept over every input position
    for (int k = 0; k < N; k++) begin
      for (int n = 0; n < N; n++) begin
        xr[n] = 0;
        xi[n] = 0;
      end
      xr[k] = 12000;
      xi[k] = -7000 + 50 * k;
      run_symbol("R6");
    end
    // near full-scale constant: only output 0 nonzero, no wrap (R7)
    for (int n = 0; n < N; n++) begin
      xr[n] = 23000;
      xi[n] = -23000;
    end
    run_symbol("R7");
    check(sx(ore[0], 0) == 23000, "R7", "dc real", sx(ore[0], 0), 23000);
    check(sx(oim[0], 0) == -23000, "R7", "dc imag", sx(oim[0], 0), -23000);
    // random symbols
    for (int s = 0; s < 8; s++) begin
      for (int n = 0; n < N; n++) begin
        xr[n] = int'($urandom_range(16000, 0)) - 8000;
        xi[n] = int'($urandom_range(16000, 0)) - 8000;
      end
      run_symbol("R6");
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule